// File: doc/BRIEF.md
# Latency-Matched Hit Buffer with Trigger Selection

This block sits at the foot of a pixel-column readout. The pixel array pushes hit records into it without any request from the readout. Each record carries a row, a column, and two timestamps: one taken when the hit rose above threshold and one taken when it fell back. Both come from a shared 7-bit crossing counter that the block runs and also drives out. On entry the block stores the hit and its time-over-threshold (TOT). An unflagged hit waits until its age passes the programmed latency, and is then removed.

A trigger pulse marks every stored hit whose rising-edge time equals the crossing exactly one latency before the trigger. Each marked hit is tagged with a 4-bit trigger number. Tagged hits leave through a valid/ready port as a word holding trigger number, row, column and TOT. Words for older triggers leave first. Within one trigger, lower buffer slots leave first. All timestamp arithmetic wraps modulo 128.

Top module: `hit_latency_buffer`

## Requirements
- R1: `ts` is 0 after reset, rises by one on every clock edge, and wraps from 127 to 0.
- R2: the TOT of a stored hit is (`hit_te` − `hit_le`) modulo 128. For example, rising edge 124 and falling edge 3 give TOT 7.
- R3: a `trigger` in the cycle where `ts` = T marks every stored, unmarked hit whose rising-edge time equals (T − `latency`) mod 128. A hit presented in that same cycle is not examined by that trigger. When its trigger is the oldest pending one, a marked hit appears on the output one cycle after the trigger.
- R4: at each clock edge, an unmarked hit whose age (`ts` − rising edge) mod 128 is greater than `latency` is removed. A removed hit is never output, even if a later trigger targets its rising-edge time.
- R5: the trigger number is a 4-bit count of the triggers seen since reset, wrapping mod 16. A trigger uses the count value before it increments, so the first trigger after reset has number 0.
- R6: words leave in increasing trigger number. Within one trigger they leave lowest slot first. A new hit takes the lowest free slot, so slots fill from slot 0 upward.
- R7: the buffer holds 16 hits. A hit presented while all 16 slots are occupied is dropped and sets `overflow`. `overflow` stays set until reset.
- R8: while `out_valid` is high and `out_ready` is low, the output word stays unchanged. A word is removed only when it is accepted, and the next word appears no earlier than the following cycle.
- R9: after reset, `out_valid` and `overflow` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latency | input | 7 | Trigger latency in crossings |
| hit_valid | input | 1 | Hit record present this cycle |
| hit_row | input | 8 | Row address of the hit |
| hit_col | input | 5 | Column address of the hit |
| hit_le | input | 7 | Timestamp at rising edge |
| hit_te | input | 7 | Timestamp at falling edge |
| trigger | input | 1 | Trigger pulse |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Readout accepts the word |
| out_tid | output | 4 | Trigger number of the word |
| out_row | output | 8 | Row address of the word |
| out_col | output | 5 | Column address of the word |
| out_tot | output | 7 | TOT of the word |
| ts | output | 7 | Current crossing timestamp |
| overflow | output | 1 | Sticky buffer-full drop flag |

## Verification
The bench builds the block with its default parameters: a 7-bit timestamp, 16 slots and a 4-bit trigger number. The 7-bit timestamp means the counter wraps every 128 cycles, so trigger matching and aging are exercised across many wraps. This includes a directed hit whose TOT wraps and whose trigger target lies on the far side of the wrap. With 16 slots, a burst of 17 hits under a long latency reaches the overflow case. With a 4-bit trigger number, the random run cycles the number through several full wraps while triggers that select no hits are skipped.

// File: rtl/hit_latency_buffer.sv
module hit_latency_buffer #(
  parameter int TS_W  = 7,
  parameter int ROW_W = 8,
  parameter int COL_W = 5,
  parameter int DEPTH = 16,
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  latency,
  input  logic             hit_valid,
  input  logic [ROW_W-1:0] hit_row,
  input  logic [COL_W-1:0] hit_col,
  input  logic [TS_W-1:0]  hit_le,
  input  logic [TS_W-1:0]  hit_te,
  input  logic             trigger,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TID_W-1:0] out_tid,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic [TS_W-1:0]  out_tot,
  output logic [TS_W-1:0]  ts,
  output logic             overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] e_v, e_f;
  logic [TID_W-1:0] e_tid [DEPTH];
  logic [ROW_W-1:0] e_row [DEPTH];
  logic [COL_W-1:0] e_col [DEPTH];
  logic [TS_W-1:0]  e_le  [DEPTH];
  logic [TS_W-1:0]  e_tot [DEPTH];

  logic [TID_W-1:0] trig_cnt, rd_tid;
  logic [TS_W-1:0]  target;
  logic [TS_W-1:0]  age [DEPTH];
  logic [DEPTH-1:0] stale, on_tgt, rd_m;
  logic [IDX_W-1:0] sel, free_idx;
  logic             pop, full, wr_en;

  assign target    = ts - latency;
  assign full      = &e_v;
  assign wr_en     = hit_valid & ~full;
  assign out_valid = |rd_m;
  assign pop       = out_valid & out_ready;
  assign out_tid   = e_tid[sel];
  assign out_row   = e_row[sel];
  assign out_col   = e_col[sel];
  assign out_tot   = e_tot[sel];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i]    = ts - e_le[i];
      stale[i]  = age[i] > latency;
      on_tgt[i] = e_le[i] == target;
      rd_m[i]   = e_v[i] & e_f[i] & (e_tid[i] == rd_tid);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rd_m[i]) sel = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_v[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts       <= '0;
      trig_cnt <= '0;
      rd_tid   <= '0;
      overflow <= 1'b0;
      e_v      <= '0;
      e_f      <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_tid[i] <= '0;
        e_row[i] <= '0;
        e_col[i] <= '0;
        e_le[i]  <= '0;
        e_tot[i] <= '0;
      end
    end else begin
      ts <= ts + 1'b1;
      if (trigger) trig_cnt <= trig_cnt + 1'b1;
      if (hit_valid && full) overflow <= 1'b1;
      if (!out_valid && rd_tid != trig_cnt) rd_tid <= rd_tid + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (e_v[i]) begin
          if (e_f[i]) begin
            if (pop && sel == IDX_W'(i)) e_v[i] <= 1'b0;
          end else if (trigger && on_tgt[i]) begin
            e_f[i]   <= 1'b1;
            e_tid[i] <= trig_cnt;
          end else if (stale[i]) begin
            e_v[i] <= 1'b0;
          end
        end else if (wr_en && free_idx == IDX_W'(i)) begin
          e_v[i]   <= 1'b1;
          e_f[i]   <= 1'b0;
          e_row[i] <= hit_row;
          e_col[i] <= hit_col;
          e_le[i]  <= hit_le;
          e_tot[i] <= hit_te - hit_le;
        end
      end
    end
  end
endmodule

// File: rtl/hit_latency_buffer_chk.sv
module hit_latency_buffer_chk #(
  parameter int TS_W  = 7,
  parameter int ROW_W = 8,
  parameter int COL_W = 5,
  parameter int TID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_valid,
  input logic             trigger,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TID_W-1:0] out_tid,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic [TS_W-1:0]  out_tot,
  input logic [TS_W-1:0]  ts,
  input logic             overflow,
  input logic             full,
  input logic [TID_W-1:0] trig_cnt
);
  p_ts_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (ts - $past(ts)) == TS_W'(1));

  p_tid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (trig_cnt - $past(trig_cnt)) == TID_W'(1));

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && full |=> overflow);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tid) && $stable(out_row)
                                && $stable(out_col) && $stable(out_tot));
endmodule

bind hit_latency_buffer hit_latency_buffer_chk #(
  .TS_W(TS_W), .ROW_W(ROW_W), .COL_W(COL_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .trigger(trigger),
  .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
  .out_row(out_row), .out_col(out_col), .out_tot(out_tot), .ts(ts),
  .overflow(overflow), .full(full), .trig_cnt(trig_cnt)
);

// File: tb/tb_hit_latency_buffer.sv
module tb_hit_latency_buffer;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] latency = 7'd4;
  logic hit_valid = 1'b0, trigger = 1'b0, out_ready = 1'b0;
  logic [7:0] hit_row = '0;
  logic [4:0] hit_col = '0;
  logic [6:0] hit_le = '0, hit_te = '0;
  logic out_valid, overflow;
  logic [3:0] out_tid;
  logic [7:0] out_row;
  logic [4:0] out_col;
  logic [6:0] out_tot, ts;

  hit_latency_buffer dut (
    .clk(clk), .rst_n(rst_n), .latency(latency), .hit_valid(hit_valid),
    .hit_row(hit_row), .hit_col(hit_col), .hit_le(hit_le), .hit_te(hit_te),
    .trigger(trigger), .out_valid(out_valid), .out_ready(out_ready),
    .out_tid(out_tid), .out_row(out_row), .out_col(out_col), .out_tot(out_tot),
    .ts(ts), .overflow(overflow)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  // stimulus for the next cycle
  logic s_hit = 0, s_trig = 0, s_ready = 1;
  logic [7:0] s_row = '0;
  logic [4:0] s_col = '0;
  logic [6:0] s_le = '0, s_te = '0;

  // expected-state model built from the requirements
  logic       m_v [N], m_f [N];
  logic [3:0] m_tid [N];
  logic [7:0] m_row [N];
  logic [4:0] m_col [N];
  logic [6:0] m_le [N], m_tot [N];
  logic [6:0] m_ts;
  logic [3:0] m_cnt, m_rd;
  logic       m_ovf;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at time %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_slot();
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_f[i] && m_tid[i] == m_rd) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_f[i] = 0; m_tid[i] = '0; m_row[i] = '0;
      m_col[i] = '0; m_le[i] = '0; m_tot[i] = '0;
    end
    m_ts = '0; m_cnt = '0; m_rd = '0; m_ovf = 0;
  endtask

  task automatic step();
    int es, fi;
    logic [6:0] tgt;
    es = exp_slot();
    chk("R1 ts", ts, m_ts);
    chk("R3 out_valid", out_valid, es >= 0);
    chk("R7 overflow", overflow, m_ovf);
    if (es >= 0 && out_valid) begin
      chk("R5 out_tid", out_tid, m_tid[es]);
      chk("R6 out_row", out_row, m_row[es]);
      chk("R6 out_col", out_col, m_col[es]);
      chk("R2 out_tot", out_tot, m_tot[es]);
    end
    hit_valid = s_hit; hit_row = s_row; hit_col = s_col;
    hit_le = s_le; hit_te = s_te; trigger = s_trig; out_ready = s_ready;
    tgt = m_ts - latency;
    fi = -1;
    for (int i = 0; i < N; i++) if (!m_v[i] && fi < 0) fi = i;
    for (int i = 0; i < N; i++) begin
      if (m_v[i]) begin
        if (m_f[i]) begin
          if (es == i && s_ready) m_v[i] = 0;
        end else if (s_trig && m_le[i] == tgt) begin
          m_f[i] = 1; m_tid[i] = m_cnt;
        end else if (7'(m_ts - m_le[i]) > latency) begin
          m_v[i] = 0;
        end
      end else if (s_hit && fi == i) begin
        m_v[i] = 1; m_f[i] = 0; m_row[i] = s_row; m_col[i] = s_col;
        m_le[i] = s_le; m_tot[i] = 7'(s_te - s_le);
      end
    end
    if (s_hit && fi < 0) m_ovf = 1;
    if (es < 0 && m_rd != m_cnt) m_rd = m_rd + 1'b1;
    if (s_trig) m_cnt = m_cnt + 1'b1;
    m_ts = m_ts + 1'b1;
    s_hit = 0; s_trig = 0;
    @(negedge clk);
  endtask

  task automatic put_hit(logic [7:0] r, logic [4:0] c, logic [6:0] le, logic [6:0] te);
    s_hit = 1; s_row = r; s_col = c; s_le = le; s_te = te;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [6:0] l0, t0;
    int k;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    chk("R9 out_valid after reset", out_valid, 0);
    chk("R9 overflow after reset", overflow, 0);
    chk("R9 ts after reset", ts, 0);

    // R2/R3: TOT wrap and trigger target across timestamp wrap
    latency = 7'd4;
    while (m_ts != 7'd124) step();
    put_hit(8'd5, 5'd2, 7'd124, 7'd3);
    step();
    while (m_ts != 7'd0) step();
    s_trig = 1;
    step();
    chk("R3 wrapped target flagged", out_valid, 1);
    chk("R2 wrapped tot", out_tot, 7);
    chk("R6 row of wrapped hit", out_row, 5);
    chk("R5 first trigger id", out_tid, 0);
    s_ready = 1;
    step();
    chk("R8 word removed after accept", out_valid, 0);

    // R4: aged hit is removed and a later trigger finds nothing
    latency = 7'd4;
    l0 = m_ts;
    put_hit(8'd9, 5'd9, l0, l0 + 7'd2);
    step();
    while (m_ts != 7'(l0 + 7'd6)) step();
    latency = 7'd6;
    s_trig = 1;
    step();
    chk("R4 aged hit not output", out_valid, 0);
    step();
    chk("R4 aged hit still absent", out_valid, 0);

    // R7: overflow after 16 occupants
    latency = 7'd100;
    for (int i = 0; i < 16; i++) begin
      put_hit(8'(20 + i), 5'(i), m_ts, m_ts + 7'd1);
      step();
    end
    chk("R7 no overflow at 16", overflow, 0);
    put_hit(8'd99, 5'd1, m_ts, m_ts);
    step();
    chk("R7 overflow at 17th", overflow, 1);
    latency = 7'd10;
    repeat (20) step();
    chk("R7 overflow sticky", overflow, 1);

    // R6/R8: ordering and stall
    latency = 7'd3;
    s_ready = 0;
    t0 = m_ts;
    put_hit(8'd10, 5'd1, t0, t0 + 7'd4); step();
    put_hit(8'd11, 5'd2, t0, t0 + 7'd5); step();
    put_hit(8'd12, 5'd3, t0 + 7'd2, t0 + 7'd6); step();
    s_trig = 1; step();
    step();
    s_trig = 1; step();
    repeat (3) begin
      chk("R8 stalled row", out_row, 10);
      step();
    end
    s_ready = 1;
    step();
    chk("R6 second slot next", out_row, 11);
    step();
    k = 0;
    while (!out_valid && k < 5) begin step(); k++; end
    chk("R6 later trigger last", out_row, 12);
    step();

    // random phases
    for (int ph = 0; ph < 2; ph++) begin
      latency = ph == 0 ? 7'd12 : 7'd40;
      for (int c = 0; c < 4000; c++) begin
        if ($urandom % 3 == 0)
          put_hit(8'($urandom), 5'($urandom), m_ts - 7'($urandom % 3), 7'($urandom));
        s_trig  = ($urandom % 8) == 0;
        s_ready = ($urandom % 4) != 0;
        step();
      end
    end
    summary();
  end
endmodule